// File: doc/BRIEF.md
# Multicycle Constant-Adder CPU Core

This block runs a five-instruction program one instruction at a time. All arithmetic goes through a single adder. The adder's second operand is a constant: 1 when it steps the program counter, 4 when it serves an add instruction. A Moore state machine steps through the phases of each instruction and sets the datapath multiplexers in each state. The multiplexers are the adder's A-operand source, the constant select, the register write-data source and the program-counter source. An instruction register holds the fetched word. An accumulator register captures the adder result on every clock.

Add-by-eight has no adder of its own. It runs the adder twice, and the second pass takes its A operand from the accumulator. The program counter advances during fetch and takes its value before the accumulator, from the adder output. A conditional branch loads a 16-bit absolute target only when its source register holds zero. The program memory is a small internal array. The bench writes it through a load port while reset is held. Register-file writes come out on observation ports.

States and transitions. After reset the core is in FETCH, which always goes to DECODE. DECODE goes to BRANCH on a branch, to ADD_A on either add, to MOV_WB on a move, and back to FETCH when no opcode flag is set. ADD_A goes to ADD_B for add-by-eight and to ADD_WB for add-by-four. ADD_B goes to ADD_WB. BRANCH, ADD_WB and MOV_WB each return to FETCH.

Top module: `mc_cpu`

## Requirements
- R1: While `rst_n` is low, the program counter is 0, the state is FETCH (code 0), the register file reads as zero and no register write is signalled.
- R2: The instruction word is decoded as follows. Bit 31 is move, bit 30 is branch-if-zero, bit 29 is add-four and bit 28 is add-eight. Bits [27:12] are the branch target, bits [7:4] the destination register and bits [3:0] the source register. Bits [11:8] are ignored.
- R3: FETCH loads the instruction register from program memory at the PC and writes PC+1, formed by the shared adder, into the PC. The next state is always DECODE.
- R4: A word with no opcode flag set takes two cycles (FETCH, DECODE) and writes no register.
- R5: A move takes three cycles and writes the source register's value into the destination register in its third cycle.
- R6: An add-four takes four cycles and writes source+4 into the destination in its fourth cycle.
- R7: An add-eight takes five cycles. Its second adder pass adds 4 to the accumulator. It writes source+8 into the destination in its fifth cycle.
- R8: A branch takes three cycles. When the source register is zero, the PC becomes the target field.
- R9: When the branch source register is non-zero, the PC is left unchanged and execution continues at the next word.
- R10: The PC changes only in FETCH and in a taken branch. A register write lasts one cycle and is always followed by FETCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Program memory write strobe |
| imem_waddr | input | 6 | Program memory write address |
| imem_wdata | input | 32 | Program memory write word |
| pc_o | output | 16 | Current program counter |
| state_o | output | 3 | Controller state code (FETCH=0 ... MOV_WB=6) |
| rf_we_o | output | 1 | Register write in this cycle |
| rf_waddr_o | output | 4 | Register being written |
| rf_wdata_o | output | 32 | Value being written |

## Verification
The test program puts each instruction kind into a fixed sequence, so the order and cycle of every register write show which state path was taken. Two add-eights are included: one reads a register written just before, and one reads and writes the same register. Together they separate a correct second pass from a single pass or from a stale operand. A not-taken branch on a non-zero register and a taken branch that skips three writing instructions show the zero qualification and the target load. A no-op placed between writes must leave the write stream untouched and must take exactly two cycles. A final self-branch must hold the PC at its own address.

// File: rtl/mc_cpu_pkg.sv
package mc_cpu_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_BRANCH = 3'd2,
        ST_ADD_A  = 3'd3,
        ST_ADD_B  = 3'd4,
        ST_ADD_WB = 3'd5,
        ST_MOV_WB = 3'd6
    } state_t;

    typedef enum logic [1:0] {
        ASEL_PC  = 2'd0,
        ASEL_REG = 2'd1,
        ASEL_ACC = 2'd2
    } asel_t;

    typedef struct packed {
        logic  ir_load;
        logic  pc_write;
        logic  pc_write_zero;
        logic  pc_from_target;
        asel_t a_sel;
        logic  inc_four;
        logic  rf_write;
        logic  wd_from_alu;
    } ctrl_t;

    localparam int unsigned INSTR_W     = 32;
    localparam int unsigned REG_FIELD_W = 4;
    localparam int unsigned BIT_MOV     = 31;
    localparam int unsigned BIT_BZ      = 30;
    localparam int unsigned BIT_ADD4    = 29;
    localparam int unsigned BIT_ADD8    = 28;
    localparam int unsigned TGT_LSB     = 12;
    localparam int unsigned DST_LSB     = 4;
    localparam int unsigned SRC_LSB     = 0;

endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic         inc_four,
    output logic [W-1:0] sum
);
    localparam logic [W-1:0] K_ONE  = W'(1);
    localparam logic [W-1:0] K_FOUR = W'(4);

    assign sum = a + (inc_four ? K_FOUR : K_ONE);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   op_mov,
    input  logic   op_bz,
    input  logic   op_add4,
    input  logic   op_add8,
    output state_t state,
    output ctrl_t  ctl
);
    state_t nxt;

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (op_bz)                 nxt = ST_BRANCH;
                else if (op_add4 || op_add8) nxt = ST_ADD_A;
                else if (op_mov)           nxt = ST_MOV_WB;
                else                       nxt = ST_FETCH;
            end
            ST_ADD_A:  nxt = op_add8 ? ST_ADD_B : ST_ADD_WB;
            ST_ADD_B:  nxt = ST_ADD_WB;
            ST_BRANCH, ST_ADD_WB, ST_MOV_WB: nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    always_comb begin
        ctl = '0;
        ctl.a_sel = ASEL_PC;
        unique case (state)
            ST_FETCH: begin
                ctl.ir_load  = 1'b1;
                ctl.pc_write = 1'b1;
            end
            ST_BRANCH: begin
                ctl.pc_write_zero  = 1'b1;
                ctl.pc_from_target = 1'b1;
            end
            ST_ADD_A: begin
                ctl.a_sel    = ASEL_REG;
                ctl.inc_four = 1'b1;
            end
            ST_ADD_B: begin
                ctl.a_sel    = ASEL_ACC;
                ctl.inc_four = 1'b1;
            end
            ST_ADD_WB: begin
                ctl.rf_write    = 1'b1;
                ctl.wd_from_alu = 1'b1;
            end
            ST_MOV_WB: ctl.rf_write = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PC_W       = 16,
    parameter int unsigned IMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] imem_waddr,
    input  logic [INSTR_W-1:0]            imem_wdata,
    output logic [PC_W-1:0]               pc_o,
    output logic [2:0]                    state_o,
    output logic                          rf_we_o,
    output logic [REG_FIELD_W-1:0]        rf_waddr_o,
    output logic [DATA_W-1:0]             rf_wdata_o
);
    localparam int unsigned IMEM_AW = $clog2(IMEM_DEPTH);

    logic [INSTR_W-1:0] imem [IMEM_DEPTH];
    logic [INSTR_W-1:0] ir_q;
    logic [PC_W-1:0]    pc_q;
    logic [DATA_W-1:0]  acc_q;
    logic [DATA_W-1:0]  alu_a;
    logic [DATA_W-1:0]  alu_sum;
    logic [DATA_W-1:0]  src_val;
    logic               src_zero;
    logic [PC_W-1:0]    target;
    state_t             state;
    ctrl_t              ctl;
    logic               unused_spare;

    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end

    mc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_mov  (ir_q[BIT_MOV]),
        .op_bz   (ir_q[BIT_BZ]),
        .op_add4 (ir_q[BIT_ADD4]),
        .op_add8 (ir_q[BIT_ADD8]),
        .state   (state),
        .ctl     (ctl)
    );

    mc_regfile #(.W(DATA_W), .AW(REG_FIELD_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we_o),
        .waddr (rf_waddr_o),
        .wdata (rf_wdata_o),
        .raddr (ir_q[SRC_LSB +: REG_FIELD_W]),
        .rdata (src_val)
    );

    always_comb begin
        unique case (ctl.a_sel)
            ASEL_PC:  alu_a = DATA_W'(pc_q);
            ASEL_REG: alu_a = src_val;
            ASEL_ACC: alu_a = acc_q;
            default:  alu_a = '0;
        endcase
    end

    mc_alu #(.W(DATA_W)) u_alu (
        .a        (alu_a),
        .inc_four (ctl.inc_four),
        .sum      (alu_sum)
    );

    assign src_zero     = (src_val == '0);
    assign target       = ir_q[TGT_LSB +: PC_W];
    assign unused_spare = ^ir_q[11:8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            pc_q  <= '0;
            acc_q <= '0;
        end else begin
            acc_q <= alu_sum;
            if (ctl.ir_load) ir_q <= imem[pc_q[IMEM_AW-1:0]];
            if (ctl.pc_write || (ctl.pc_write_zero && src_zero))
                pc_q <= ctl.pc_from_target ? target : alu_sum[PC_W-1:0];
        end
    end

    assign rf_we_o    = ctl.rf_write;
    assign rf_waddr_o = ir_q[DST_LSB +: REG_FIELD_W];
    assign rf_wdata_o = ctl.wd_from_alu ? acc_q : src_val;
    assign pc_o       = pc_q;
    assign state_o    = state;
endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk
    import mc_cpu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input state_t      state,
    input logic [15:0] pc_q,
    input logic [31:0] ir_q,
    input logic        src_zero,
    input logic        rf_we
);
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> (pc_q == $past(pc_q) + 16'd1) && state == ST_DECODE); // R3

    AST_NOP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && ir_q[31:28] == 4'd0) |=> state == ST_FETCH); // R4

    AST_ADD8_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADD_B |-> $past(state) == ST_ADD_A); // R7

    AST_BZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRANCH && src_zero) |=> pc_q == $past(ir_q[27:12])); // R8

    AST_BZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRANCH && !src_zero) |=> $stable(pc_q)); // R9

    AST_PC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH && state != ST_BRANCH) |=> $stable(pc_q)); // R10

    AST_WR_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (state == ST_FETCH && !rf_we)); // R10
endmodule

bind mc_cpu mc_cpu_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .pc_q     (pc_q),
    .ir_q     (ir_q),
    .src_zero (src_zero),
    .rf_we    (rf_we_o)
);

// File: tb/mc_cpu_tb_top.sv
module mc_cpu_tb_top;
    typedef struct {
        logic [3:0]  addr;
        logic [31:0] data;
        int          cyc;
        string       req;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [15:0] pc_o;
    logic [2:0]  state_o;
    logic        rf_we_o;
    logic [3:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit run    = 1'b0;
    bit done   = 1'b0;
    wr_item_t exp_q[$];

    always #4 clk = ~clk;

    mc_cpu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .pc_o       (pc_o),
        .state_o    (state_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_write(input logic [3:0] a, input logic [31:0] d, input int c, input string req);
        wr_item_t it;
        it.addr = a; it.data = d; it.cyc = c; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic load(input int a, input logic [31:0] w);
        @(negedge clk);
        imem_we = 1'b1; imem_waddr = 6'(a); imem_wdata = w;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    always @(posedge clk) if (run) cyc++;

    // scoreboard monitor
    always @(negedge clk) begin
        if (run && !done && rf_we_o) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected write", 1'b0, rf_waddr_o, 0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check({it.req, " data"}, rf_waddr_o == it.addr && rf_wdata_o == it.data,
                      {rf_waddr_o, rf_wdata_o}, {it.addr, it.data});
                check({it.req, " cycle"}, cyc == it.cyc, cyc, it.cyc);
            end
        end
    end

    // point checks on PC and state
    always @(negedge clk) begin
        if (run && !done) begin
            case (cyc)
                12: check("R4 nop fetch pc", state_o == 3'd0 && pc_o == 16'd3, pc_o, 3);
                14: check("R4 nop two cycles", state_o == 3'd0 && pc_o == 16'd4, pc_o, 4);
                17: check("R9 not taken pc", state_o == 3'd0 && pc_o == 16'd5, pc_o, 5);
                25: check("R8 taken pc", state_o == 3'd0 && pc_o == 16'd10, pc_o, 10);
                35: check("R8 self loop pc", state_o == 3'd0 && pc_o == 16'd12, pc_o, 12);
                38: check("R10 loop holds", state_o == 3'd0 && pc_o == 16'd12, pc_o, 12);
                default: ;
            endcase
        end
    end

    initial begin
        // R2 encodings: [31]MOV [30]BZ [29]ADD4 [28]ADD8 [27:12]target [7:4]dst [3:0]src
        load(0,  32'h2000_0010);   // add4 r1,r0
        load(1,  32'h1000_0021);   // add8 r2,r1
        load(2,  32'h8000_0032);   // mov  r3,r2
        load(3,  32'h0000_0045);   // nop
        load(4,  32'h4000_9071);   // bz r1 -> 9 (not taken)
        load(5,  32'h1000_0044);   // add8 r4,r4
        load(6,  32'h4000_A0F0);   // bz r0 -> 10 (taken)
        load(7,  32'h8000_0051);
        load(8,  32'h2000_0060);
        load(9,  32'h2000_0070);
        load(10, 32'h2000_0083);   // add4 r8,r3
        load(11, 32'h8000_0094);   // mov  r9,r4
        load(12, 32'h4000_C000);   // bz r0 -> 12
        @(negedge clk);
        check("R1 reset pc", pc_o == 16'd0, pc_o, 0);
        check("R1 reset state", state_o == 3'd0, state_o, 0);
        check("R1 reset no write", rf_we_o == 1'b0, rf_we_o, 0);

        expect_write(4'd1, 32'd4,  3,  "R6 add4 of zeroed r0 (R1)");
        expect_write(4'd2, 32'd12, 8,  "R7 add8");
        expect_write(4'd3, 32'd12, 11, "R5 mov");
        expect_write(4'd4, 32'd8,  21, "R7 add8 same reg");
        expect_write(4'd8, 32'd16, 28, "R6 add4 after branch");
        expect_write(4'd9, 32'd8,  31, "R5 mov after branch");

        rst_n = 1'b1;
        run   = 1'b1;
        wait (cyc >= 60);
        @(negedge clk);
        done = 1'b1;
        check("R10 all writes seen", exp_q.size() == 0, exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule